// File: doc/BRIEF.md
# Active-Low Framed Stream Source

This block sits at the read-return side of a bus master. Read beats arrive one word at a time on a valid/ready input. Each beat comes with a first-beat mark, a last-beat mark and a byte-valid mask for the last beat. The block passes them on to user logic as an active-low, frame-delimited stream. A two-entry skid store sits between the two sides. The upstream side therefore runs at one beat per clock whenever the sink keeps up, and nothing is dropped or repeated while the sink throttles.

Back-pressure rules:
- Upstream may offer a beat at any time by raising `in_valid`. The beat is taken on a clock edge where `in_valid` and `in_ready` are both high.
- Downstream takes a beat on an edge where `out_src_rdy_n` and `out_dst_rdy_n` are both low.
- While downstream is not ready, the presented beat and its marks stay frozen.

An abort pulse, raised by the bus side when an address phase times out, does three things:
- It empties the store.
- It marks the stream with a one-cycle source-discontinue pulse when data of the current frame would be lost.
- It forces the next accepted beat to open a new frame.

The sink's own discontinue input has no effect.

Top module: `framed_stream_src`

## Requirements
- R1: During and directly after reset, `out_sof_n`, `out_eof_n`, `out_src_rdy_n` and `out_src_dsc_n` are 1, `out_data` and `out_rem_n` are all zeros, and `in_ready` is 1.
- R2: A beat accepted on an input edge is presented from that edge on. A presented beat leaves only on an edge where `out_src_rdy_n` and `out_dst_rdy_n` are both low. While it waits, data, marks and mask stay unchanged. Beats leave in arrival order, each exactly once.
- R3: `out_sof_n` is low on a beat whose first mark was set, and `out_eof_n` is low on a beat whose last mark was set. A beat with both marks drives both low together. Both are 1 while no beat is presented.
- R4: `out_rem_n` is an active-low byte mask with DATA_W/8 bits. On a last beat it equals the bitwise inverse of `in_keep`. On any other beat it is all zeros. Bit DATA_W/8-1-k covers byte lane k, and lane 0 is data bits DATA_W-1 down to DATA_W-8, the most significant byte.
- R5: `in_ready` is 1 while fewer than two beats are held and no abort is present. With the sink always ready, one beat per cycle flows through.
- R6: `in_ready` is 0 while two beats are held, and in any cycle where `abort_i` is high.
- R7: An abort edge discards every held beat. It drives `out_src_dsc_n` low for exactly the following cycle if a frame was open on the input side or a beat stayed undelivered. In that cycle `out_src_rdy_n` is 1.
- R8: An abort that finds no open frame and no undelivered beat leaves `out_src_dsc_n` at 1. `out_src_dsc_n` is never low except directly after an abort.
- R9: After any abort, the first beat accepted is presented with `out_sof_n` low, whatever its first mark was.
- R10: `out_dst_dsc_n` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | DATA_W | Beat data word |
| in_first | input | 1 | Beat opens a frame |
| in_last | input | 1 | Beat closes a frame |
| in_keep | input | DATA_W/8 | Active-high byte-valid mask, used on last beats |
| abort_i | input | 1 | Address-phase timeout pulse for the current frame |
| out_data | output | DATA_W | Presented data word |
| out_sof_n | output | 1 | Start of frame, active low |
| out_eof_n | output | 1 | End of frame, active low |
| out_src_rdy_n | output | 1 | Beat presented, active low |
| out_dst_rdy_n | input | 1 | Sink takes the beat, active low |
| out_rem_n | output | DATA_W/8 | Active-low valid-byte mask |
| out_src_dsc_n | output | 1 | Source discontinue, active low |
| out_dst_dsc_n | input | 1 | Sink discontinue request, ignored |

## Verification
A corrupted occupancy count or read pointer shows up at the ports within one cycle. The presented beat either differs from the oldest undelivered word, or `out_src_rdy_n` disagrees with whether a beat is owed. A stuck open-frame flag or forced-start flag stays hidden until the next abort, or the first beat after it. It then shows as a missing or spurious discontinue pulse one cycle after the abort, or a start-of-frame mark missing from the next presented beat. A mask fault shows only on last beats, so frames of varied length and keep patterns are needed to expose it.

// File: rtl/fss_pkg.sv
package fss_pkg;
  // Frame marks carried beside each stored word.
  typedef struct packed {
    logic first;
    logic last;
  } fss_mark_t;

  localparam int unsigned FSS_MARK_W = $bits(fss_mark_t);
endpackage

// File: rtl/fss_rem_gen.sv
module fss_rem_gen #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8
) (
  input  logic             last,
  input  logic [LANES-1:0] keep,
  output logic [LANES-1:0] rem_n
);
  // Bit LANES-1-k covers lane k; lane 0 is the most significant byte.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rem_n[g] = last ? ~keep[g] : 1'b0;
  end
endmodule

// File: rtl/fss_skid.sv
module fss_skid #(
  parameter int unsigned W     = 38,
  parameter int unsigned DEPTH = 2,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (clear) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= wdata;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
endmodule

// File: rtl/fss_abort_ctl.sv
module fss_abort_ctl #(
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          push,
  input  logic          push_last,
  input  logic          pop,
  input  logic [CW-1:0] count,
  output logic          need_sof,
  output logic          dsc_n
);
  logic open_q;
  logic lost;

  // Data of the current frame is lost when a frame is open upstream
  // or a held beat would remain after this edge's delivery.
  assign lost = open_q || (count > CW'(pop));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      need_sof <= 1'b0;
      dsc_n    <= 1'b1;
    end else begin
      dsc_n <= ~(abort && lost);
      if (abort) begin
        open_q   <= 1'b0;
        need_sof <= 1'b1;
      end else if (push) begin
        open_q   <= ~push_last;
        need_sof <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/framed_stream_src.sv
module framed_stream_src #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 2,
  localparam int unsigned KEEP_W = DATA_W / 8,
  localparam int unsigned ENT_W  = DATA_W + KEEP_W + fss_pkg::FSS_MARK_W,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_first,
  input  logic              in_last,
  input  logic [KEEP_W-1:0] in_keep,
  input  logic              abort_i,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sof_n,
  output logic              out_eof_n,
  output logic              out_src_rdy_n,
  input  logic              out_dst_rdy_n,
  output logic [KEEP_W-1:0] out_rem_n,
  output logic              out_src_dsc_n,
  input  logic              out_dst_dsc_n
);
  import fss_pkg::*;

  logic              push, pop, need_sof, empty;
  logic [CW-1:0]     count;
  logic [KEEP_W-1:0] rem_in;
  fss_mark_t         mark_in, mark_out;
  logic [ENT_W-1:0]  wr_ent, rd_ent;
  logic              unused_dst_dsc;

  assign unused_dst_dsc = out_dst_dsc_n;

  assign empty    = (count == '0);
  assign in_ready = (count < CW'(DEPTH)) && !abort_i;
  assign push     = in_valid && in_ready;
  assign pop      = !empty && !out_dst_rdy_n;

  fss_rem_gen #(.DATA_W(DATA_W)) rem_i (
    .last  (in_last),
    .keep  (in_keep),
    .rem_n (rem_in)
  );

  assign mark_in.first = in_first | need_sof;
  assign mark_in.last  = in_last;
  assign wr_ent        = {mark_in, rem_in, in_data};

  fss_skid #(.W(ENT_W), .DEPTH(DEPTH)) skid_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (abort_i),
    .push  (push),
    .wdata (wr_ent),
    .pop   (pop),
    .rdata (rd_ent),
    .count (count)
  );

  fss_abort_ctl #(.CW(CW)) abort_i_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort     (abort_i),
    .push      (push),
    .push_last (in_last),
    .pop       (pop),
    .count     (count),
    .need_sof  (need_sof),
    .dsc_n     (out_src_dsc_n)
  );

  assign mark_out      = fss_mark_t'(rd_ent[ENT_W-1 -: FSS_MARK_W]);
  assign out_rem_n     = rd_ent[DATA_W +: KEEP_W];
  assign out_data      = rd_ent[DATA_W-1:0];
  assign out_src_rdy_n = empty;
  assign out_sof_n     = empty | ~mark_out.first;
  assign out_eof_n     = empty | ~mark_out.last;
endmodule

// File: rtl/fss_checker.sv
module fss_checker #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned KEEP_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              abort_i,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sof_n,
  input logic              out_eof_n,
  input logic              out_src_rdy_n,
  input logic              out_dst_rdy_n,
  input logic [KEEP_W-1:0] out_rem_n,
  input logic              out_src_dsc_n
);
  p_hold_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_src_rdy_n && out_dst_rdy_n && !abort_i) |=>
      (!out_src_rdy_n && $stable(out_data) && $stable(out_sof_n) &&
       $stable(out_eof_n) && $stable(out_rem_n)));

  p_marks_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_src_rdy_n |-> (out_sof_n && out_eof_n));

  p_rem_body_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_src_rdy_n && out_eof_n) |-> (out_rem_n == '0));

  p_abort_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |-> !in_ready);

  p_dsc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_src_dsc_n |-> out_src_rdy_n);

  p_dsc_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_src_dsc_n |=> out_src_dsc_n);

  p_dsc_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_src_dsc_n) |-> $past(abort_i));
endmodule

bind framed_stream_src fss_checker #(.DATA_W(DATA_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .abort_i       (abort_i),
  .in_ready      (in_ready),
  .out_data      (out_data),
  .out_sof_n     (out_sof_n),
  .out_eof_n     (out_eof_n),
  .out_src_rdy_n (out_src_rdy_n),
  .out_dst_rdy_n (out_dst_rdy_n),
  .out_rem_n     (out_rem_n),
  .out_src_dsc_n (out_src_dsc_n)
);

// File: tb/framed_stream_src_tb.sv
module framed_stream_src_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int KW = DW / 8;

  typedef struct {
    logic [DW-1:0] data;
    bit            first;
    bit            last;
    logic [KW-1:0] rem;
  } beat_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, abort_i = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [KW-1:0] in_keep = '0;
  logic          out_dst_rdy_n = 1'b1, out_dst_dsc_n = 1'b1;
  logic          in_ready, out_sof_n, out_eof_n, out_src_rdy_n, out_src_dsc_n;
  logic [DW-1:0] out_data;
  logic [KW-1:0] out_rem_n;

  int    n_checks = 0, n_fail = 0, cycles = 0;
  string note = "";
  beat_t q[$];
  bit    m_open = 0, m_need = 0, m_dsc = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  framed_stream_src #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last), .in_keep(in_keep),
    .abort_i(abort_i), .out_data(out_data), .out_sof_n(out_sof_n),
    .out_eof_n(out_eof_n), .out_src_rdy_n(out_src_rdy_n),
    .out_dst_rdy_n(out_dst_rdy_n), .out_rem_n(out_rem_n),
    .out_src_dsc_n(out_src_dsc_n), .out_dst_dsc_n(out_dst_dsc_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s %s actual=%0h expected=%0h", req, note, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  function automatic logic [KW-1:0] exp_rem(input bit last, input logic [KW-1:0] k);
    return last ? ~k : '0;
  endfunction

  // Called at a falling edge: check presented state, drive, predict next edge.
  task automatic step(input bit vld, input logic [DW-1:0] d, input bit f,
                      input bit l, input logic [KW-1:0] k, input bit ab,
                      input bit drdy_n, input bit ddsc_n, output bit acc);
    bit exp_rdy, lost;
    chk(out_src_rdy_n == (q.size() == 0), "R2", "src_rdy_n", out_src_rdy_n, q.size() == 0);
    if (q.size() > 0) begin
      chk(out_data == q[0].data, "R2", "data", out_data, q[0].data);
      chk(out_sof_n == !q[0].first, "R3", "sof_n", out_sof_n, !q[0].first);
      chk(out_eof_n == !q[0].last, "R3", "eof_n", out_eof_n, !q[0].last);
      chk(out_rem_n == q[0].rem, "R4", "rem_n", out_rem_n, q[0].rem);
    end else begin
      chk(out_sof_n && out_eof_n, "R3", "idle marks", {out_sof_n, out_eof_n}, 2'b11);
    end
    chk(out_src_dsc_n == !m_dsc, m_dsc ? "R7" : "R8", "src_dsc_n", out_src_dsc_n, !m_dsc);
    in_valid = vld; in_data = d; in_first = f; in_last = l; in_keep = k;
    abort_i = ab; out_dst_rdy_n = drdy_n; out_dst_dsc_n = ddsc_n;
    #1;
    exp_rdy = (q.size() < 2) && !ab;
    chk(in_ready == exp_rdy, exp_rdy ? "R5" : "R6", "in_ready", in_ready, exp_rdy);
    acc = vld && exp_rdy;
    if (q.size() > 0 && !drdy_n) void'(q.pop_front());
    if (ab) begin
      lost = m_open || (q.size() > 0);
      q.delete();
      m_dsc = lost; m_open = 0; m_need = 1;
    end else begin
      m_dsc = 0;
      if (acc) begin
        beat_t b;
        b.data = d; b.first = f | m_need; b.last = l; b.rem = exp_rem(l, k);
        q.push_back(b);
        m_need = 0; m_open = !l;
      end
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit drdy_n);
    bit a;
    for (int i = 0; i < n; i++) step(0, '0, 0, 0, '0, 0, drdy_n, 1, a);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        report();
      end
    end
  end

  initial begin
    bit a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    chk(out_sof_n && out_eof_n && out_src_rdy_n && out_src_dsc_n, "R1", "flags",
        {out_sof_n, out_eof_n, out_src_rdy_n, out_src_dsc_n}, 4'hf);
    chk(out_data == '0 && out_rem_n == '0, "R1", "data/rem", {out_data, out_rem_n}, 0);
    chk(in_ready == 1'b1, "R1", "in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4: single-beat frame, lane 0 only valid
    note = "single";
    step(1, 32'hA1B2C3D4, 1, 1, 4'b1000, 0, 0, 1, a);
    idle(2, 0);

    // R6 R2: sink stalls, store fills, beats held then drained in order
    note = "stall";
    step(1, 32'h11, 1, 0, '0, 0, 1, 1, a);
    step(1, 32'h22, 0, 0, '0, 0, 1, 1, a);
    step(1, 32'h33, 0, 1, 4'b1100, 0, 1, 1, a);
    chk(!a, "R6", "third beat refused", a, 0);
    idle(3, 1);
    step(1, 32'h33, 0, 1, 4'b1100, 0, 0, 1, a);
    idle(4, 0);

    // R5: full-rate stream with an always-ready sink
    note = "fullrate";
    for (int i = 0; i < 8; i++) begin
      step(1, 32'h100 + i, i == 0, i == 7, 4'b1110, 0, 0, 1, a);
      chk(a, "R5", "accept every cycle", a, 1);
    end
    idle(3, 0);

    // R7 R9: abort inside an open frame, then a continuation beat
    note = "abort-open";
    step(1, 32'h55, 1, 0, '0, 0, 1, 1, a);
    step(0, '0, 0, 0, '0, 1, 1, 1, a);
    step(1, 32'h66, 0, 0, '0, 0, 1, 1, a);
    chk(out_src_dsc_n == 1'b1, "R7", "single pulse", out_src_dsc_n, 1);
    chk(out_sof_n == 1'b0, "R9", "forced sof", out_sof_n, 0);
    step(1, 32'h77, 0, 1, 4'b1111, 0, 0, 1, a);
    idle(3, 0);

    // R8: abort with nothing owed
    note = "abort-idle";
    step(0, '0, 0, 0, '0, 1, 0, 1, a);
    idle(2, 0);
    chk(out_src_dsc_n == 1'b1, "R8", "no pulse", out_src_dsc_n, 1);

    // Random traffic; phase two toggles the sink discontinue (R10)
    for (int ph = 0; ph < 2; ph++) begin
      int idx = 0, len = 1 + $urandom % 5;
      note = (ph == 0) ? "random" : "R10 dst_dsc toggled";
      for (int c = 0; c < 3000; c++) begin
        bit vld = ($urandom % 10) < 7;
        bit ab  = ($urandom % 40) == 0;
        bit dr  = ($urandom % 10) < 4;
        bit dd  = (ph == 0) ? 1'b1 : 1'($urandom % 2);
        step(vld, $urandom, idx == 0, idx == len - 1, 4'($urandom), ab, dr, dd, a);
        if (ab && ($urandom % 2)) begin
          idx = 0; len = 1 + $urandom % 5;
        end else if (a) begin
          if (idx == len - 1) begin
            idx = 0; len = 1 + $urandom % 5;
          end else idx++;
        end
      end
      idle(4, 0);
    end
    report();
  end
endmodule